// File: doc/BRIEF.md
# Delay-Locked Loop Delay-Code Controller

This block keeps the digital delay code of a delay-locked loop and derives from it the settings handed to a strobe-shift stage. On each rising edge of the reference clock, which is the block's clock, a phase detector samples the delayed copy of that clock coming back from an external tapped delay line. When an update is enabled, a saturating six-bit counter moves the code one step toward alignment. A high sample means the chain is too long, so the code goes down. A low sample means it is too short, so the code goes up.

A second stage combines the loop code with a six-bit offset supplied by the surrounding logic. It either adds or subtracts the offset and clamps the result to the code range, and the result goes only to the strobe-shift consumer. The plain loop code goes to both the fabric and the strobe-shift consumer. A zero-degree select bypasses both the loop and the strobe path. While it is asserted, the loop stops updating, both strobe codes read zero, and a bypass flag tells the strobe stage to pass the strobe through undelayed.

A lock flag rises once the detector's decision has flipped on several consecutive updates, which shows the code is dithering around the aligned point. The flag stays set until the next reset.

Top module: `dll_code_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is `loop_code` = 32 and `locked` = 0. Reset is synchronous and active high.
- R2: The phase detector registers `dly_in` on every rising edge of `clk`. An enabled update uses the most recently registered sample. A sample of 1 lowers `loop_code` by exactly 1 and a sample of 0 raises it by exactly 1, visible after the updating edge.
- R3: At an edge where `upd_en` is 0, `loop_code` does not change, whatever `dly_in` does.
- R4: `loop_code` saturates. A decrement at 0 leaves it at 0 and an increment at 63 leaves it at 63. It never wraps.
- R5: With `zero_shift` = 0, `strobe_adj` equals min(`loop_code` + `ofs_val`, 63) when `ofs_sub` = 0, and max(`loop_code` − `ofs_val`, 0) when `ofs_sub` = 1.
- R6: With `zero_shift` = 0, `strobe_base` equals `loop_code` and `strobe_bypass` is 0.
- R7: With `zero_shift` = 1, `strobe_bypass` = 1 and `strobe_base` = `strobe_adj` = 0. Enabled updates have no effect on `loop_code` or on lock tracking. `loop_code` keeps its value on the fabric output.
- R8: An update counts as alternating when its direction differs from that of the previous counted update. `locked` goes to 1 at the edge that completes 4 consecutive alternating updates. A non-alternating update restarts the run, and the first update after reset starts it.
- R9: Once set, `locked` stays 1 until a reset, whatever later updates do. A reset clears it and restarts run tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the phase detector samples on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Update enable for the delay-code counter |
| dly_in | input | 1 | Delayed reference returning from the last element of the delay line |
| ofs_val | input | 6 | Phase offset from the fabric |
| ofs_sub | input | 1 | 1 subtracts the offset, 0 adds it |
| zero_shift | input | 1 | Zero-degree shift select; bypasses loop and strobe path |
| loop_code | output | 6 | Unadjusted delay code to the fabric |
| strobe_base | output | 6 | Unadjusted delay code to the strobe-shift stage |
| strobe_adj | output | 6 | Offset-adjusted code to the strobe-shift stage |
| strobe_bypass | output | 1 | Tells the strobe stage to pass the strobe undelayed |
| locked | output | 1 | Loop lock indication, sticky until reset |

## Verification
Two things can land on the same edge: an enabled update arriving while the code sits at a rail, and an update arriving while the zero-degree bypass is asserted. The bench drives the code up to 63 and down to 0 and then keeps issuing same-direction updates, expecting the value to hold rather than wrap. It also issues updates of both directions under bypass and expects the code and lock state to stay frozen while the strobe outputs read zero. At every code value the adjusted strobe code is compared against saturated arithmetic for all 64 offsets in both add and subtract mode.

// File: rtl/dll_pkg.sv
package dll_pkg;

    localparam int CODE_W   = 6;
    localparam int CODE_MAX = (1 << CODE_W) - 1;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic {
        STEP_UP   = 1'b0,
        STEP_DOWN = 1'b1
    } step_dir_e;

    typedef struct packed {
        code_t base;
        code_t adj;
        logic  bypass;
    } strobe_ctl_t;

    function automatic code_t sat_add(input code_t a, input code_t b);
        logic [CODE_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[CODE_W] ? code_t'(CODE_MAX) : s[CODE_W-1:0];
    endfunction

    function automatic code_t sat_sub(input code_t a, input code_t b);
        return (a < b) ? code_t'(0) : code_t'(a - b);
    endfunction

endpackage

// File: rtl/dll_phase_cmp.sv
module dll_phase_cmp
    import dll_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      dly_in,
    output step_dir_e dir
);
    logic smp_q;

    always_ff @(posedge clk) begin
        if (rst) smp_q <= 1'b0;
        else     smp_q <= dly_in;
    end

    assign dir = smp_q ? STEP_DOWN : STEP_UP;
endmodule

// File: rtl/dll_code_cnt.sv
module dll_code_cnt
    import dll_pkg::*;
#(
    parameter int RESET_CODE = 32,
    parameter int LOCK_RUNS  = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      step_en,
    input  step_dir_e dir,
    output code_t     code,
    output logic      locked
);
    localparam int RUN_W = $clog2(LOCK_RUNS + 1);

    code_t            code_q;
    logic             lock_q;
    logic             have_prev_q;
    step_dir_e        prev_dir_q;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_nxt;

    always_comb begin
        if (have_prev_q && (dir != prev_dir_q)) begin
            run_nxt = (run_q == RUN_W'(LOCK_RUNS)) ? run_q : run_q + 1'b1;
        end else begin
            run_nxt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q      <= code_t'(RESET_CODE);
            lock_q      <= 1'b0;
            have_prev_q <= 1'b0;
            prev_dir_q  <= STEP_UP;
            run_q       <= '0;
        end else if (step_en) begin
            code_q      <= (dir == STEP_DOWN) ? sat_sub(code_q, code_t'(1))
                                              : sat_add(code_q, code_t'(1));
            have_prev_q <= 1'b1;
            prev_dir_q  <= dir;
            run_q       <= run_nxt;
            if (run_nxt == RUN_W'(LOCK_RUNS)) lock_q <= 1'b1;
        end
    end

    assign code   = code_q;
    assign locked = lock_q;
endmodule

// File: rtl/dll_ofs_stage.sv
module dll_ofs_stage
    import dll_pkg::*;
(
    input  code_t       code,
    input  code_t       ofs,
    input  logic        ofs_sub,
    input  logic        zero_shift,
    output strobe_ctl_t ctl
);
    always_comb begin
        if (zero_shift) begin
            ctl.base   = '0;
            ctl.adj    = '0;
            ctl.bypass = 1'b1;
        end else begin
            ctl.base   = code;
            ctl.adj    = ofs_sub ? sat_sub(code, ofs) : sat_add(code, ofs);
            ctl.bypass = 1'b0;
        end
    end
endmodule

// File: rtl/dll_code_ctrl.sv
module dll_code_ctrl
    import dll_pkg::*;
#(
    parameter int RESET_CODE = 32,
    parameter int LOCK_RUNS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic              dly_in,
    input  logic [CODE_W-1:0] ofs_val,
    input  logic              ofs_sub,
    input  logic              zero_shift,
    output logic [CODE_W-1:0] loop_code,
    output logic [CODE_W-1:0] strobe_base,
    output logic [CODE_W-1:0] strobe_adj,
    output logic              strobe_bypass,
    output logic              locked
);
    step_dir_e   dir;
    code_t       code;
    strobe_ctl_t ctl;

    dll_phase_cmp u_cmp (
        .clk    (clk),
        .rst    (rst),
        .dly_in (dly_in),
        .dir    (dir)
    );

    dll_code_cnt #(
        .RESET_CODE (RESET_CODE),
        .LOCK_RUNS  (LOCK_RUNS)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .step_en (upd_en & ~zero_shift),
        .dir     (dir),
        .code    (code),
        .locked  (locked)
    );

    dll_ofs_stage u_ofs (
        .code       (code),
        .ofs        (ofs_val),
        .ofs_sub    (ofs_sub),
        .zero_shift (zero_shift),
        .ctl        (ctl)
    );

    assign loop_code     = code;
    assign strobe_base   = ctl.base;
    assign strobe_adj    = ctl.adj;
    assign strobe_bypass = ctl.bypass;
endmodule

// File: rtl/dll_code_ctrl_chk.sv
module dll_code_ctrl_chk
    import dll_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              upd_en,
    input logic              zero_shift,
    input logic              ofs_sub,
    input logic [CODE_W-1:0] loop_code,
    input logic [CODE_W-1:0] strobe_adj,
    input logic              locked
);
    // R1
    reset_load_chk: assert property (@(posedge clk)
        rst |=> (loop_code == code_t'(32) && !locked));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(loop_code));

    // R4
    top_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (loop_code == code_t'(CODE_MAX)) |=> (loop_code != code_t'(0)));

    // R4
    bottom_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (loop_code == code_t'(0)) |=> (loop_code != code_t'(CODE_MAX)));

    // R5
    add_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (!zero_shift && !ofs_sub) |-> (strobe_adj >= loop_code));

    // R5
    sub_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (!zero_shift && ofs_sub) |-> (strobe_adj <= loop_code));

    // R7
    bypass_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        zero_shift |=> $stable(loop_code));

    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);
endmodule

bind dll_code_ctrl dll_code_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .upd_en     (upd_en),
    .zero_shift (zero_shift),
    .ofs_sub    (ofs_sub),
    .loop_code  (loop_code),
    .strobe_adj (strobe_adj),
    .locked     (locked)
);

// File: tb/sim_dll_code_ctrl.sv
`timescale 1ns/1ps
module sim_dll_code_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       upd_en = 1'b0;
    logic       dly_in = 1'b0;
    logic [5:0] ofs_val = '0;
    logic       ofs_sub = 1'b0;
    logic       zero_shift = 1'b0;
    logic [5:0] loop_code, strobe_base, strobe_adj;
    logic       strobe_bypass, locked;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int exp_code;
    bit exp_lock;
    bit have_prev;
    bit prev_d;
    int run;

    always #2.5 clk = ~clk;

    dll_code_ctrl u0 (
        .clk(clk), .rst(rst), .upd_en(upd_en), .dly_in(dly_in),
        .ofs_val(ofs_val), .ofs_sub(ofs_sub), .zero_shift(zero_shift),
        .loop_code(loop_code), .strobe_base(strobe_base), .strobe_adj(strobe_adj),
        .strobe_bypass(strobe_bypass), .locked(locked)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
        exp_code = 32; exp_lock = 0; have_prev = 0; run = 0;
    endtask

    task automatic model_step(input bit d);
        if (zero_shift) return;
        if (d) exp_code = (exp_code == 0) ? 0 : exp_code - 1;
        else   exp_code = (exp_code == 63) ? 63 : exp_code + 1;
        if (have_prev && d != prev_d) run = (run < 4) ? run + 1 : 4;
        else run = 0;
        have_prev = 1; prev_d = d;
        if (run == 4) exp_lock = 1;
    endtask

    task automatic do_update(input bit d);
        @(negedge clk) dly_in = d;
        @(negedge clk) upd_en = 1'b1;
        @(negedge clk) upd_en = 1'b0;
        model_step(d);
    endtask

    task automatic sweep_offsets();
        for (int o = 0; o < 64; o++) begin
            for (int s = 0; s < 2; s++) begin
                int e;
                ofs_val = 6'(o); ofs_sub = s[0];
                #0.1;
                if (s == 1) e = (exp_code < o) ? 0 : exp_code - o;
                else        e = (exp_code + o > 63) ? 63 : exp_code + o;
                chk("R5 adjusted code", int'(strobe_adj), e);
            end
        end
        ofs_sub = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R1 reset code", int'(loop_code), 32);
        chk("R1 reset lock", int'(locked), 0);
        chk("R6 no bypass", int'(strobe_bypass), 0);

        // R3: toggling dly_in without update enable
        for (int i = 0; i < 6; i++) begin
            @(negedge clk) dly_in = i[0];
            chk("R3 hold without enable", int'(loop_code), 32);
        end

        // R2/R4 upward ramp into the top rail
        for (int i = 0; i < 34; i++) begin
            do_update(1'b0);
            chk("R2 R4 up step", int'(loop_code), exp_code);
            chk("R6 base follows loop", int'(strobe_base), exp_code);
            sweep_offsets();
        end
        chk("R4 top rail", int'(loop_code), 63);

        // R2/R4 downward ramp into the bottom rail
        for (int i = 0; i < 66; i++) begin
            do_update(1'b1);
            chk("R2 R4 down step", int'(loop_code), exp_code);
            chk("R6 base follows loop", int'(strobe_base), exp_code);
            sweep_offsets();
        end
        chk("R4 bottom rail", int'(loop_code), 0);
        chk("R8 monotonic no lock", int'(locked), 0);

        // R7 bypass: updates frozen, strobe codes zeroed
        do_update(1'b0); do_update(1'b0);
        @(negedge clk) zero_shift = 1'b1;
        for (int i = 0; i < 6; i++) begin
            do_update(i[0]);
            chk("R7 loop frozen", int'(loop_code), exp_code);
            chk("R7 bypass flag", int'(strobe_bypass), 1);
            chk("R7 base zero", int'(strobe_base), 0);
            ofs_val = 6'd17;
            #0.1 chk("R7 adj zero", int'(strobe_adj), 0);
            chk("R7 no lock", int'(locked), 0);
        end
        @(negedge clk) zero_shift = 1'b0;
        chk("R7 code held after bypass", int'(loop_code), 2);

        // R8 clean alternation
        do_reset();
        chk("R9 reset reload", int'(loop_code), 32);
        for (int i = 0; i < 5; i++) begin
            do_update(i[0]);
            chk("R8 lock on alternation", int'(locked), int'(exp_lock));
            chk("R2 dither code", int'(loop_code), exp_code);
        end
        chk("R8 locked after run", int'(locked), 1);

        // R9 sticky through same-direction updates
        for (int i = 0; i < 4; i++) begin
            do_update(1'b1);
            chk("R9 sticky lock", int'(locked), 1);
        end
        do_reset();
        chk("R9 reset clears lock", int'(locked), 0);
        chk("R9 reset code", int'(loop_code), 32);

        // R8 interrupted run
        begin
            bit pat[8] = '{0, 1, 0, 0, 1, 0, 1, 0};
            for (int i = 0; i < 8; i++) begin
                do_update(pat[i]);
                chk("R8 interrupted run", int'(locked), int'(exp_lock));
            end
        end
        chk("R8 final lock", int'(locked), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule